// File: doc/BRIEF.md
# Segment Descriptor Load Unit

This unit takes a 64-bit segment descriptor that has already been read from a descriptor table, together with a request that names the segment register being loaded: code, stack or data. It checks the descriptor's class, type and presence against the rules for that register. It gathers the scattered base and limit fragments into one cached record, and it works out the effective byte limit from the granularity flag.

When a load succeeds and the descriptor's accessed flag is still clear, the unit issues a single-byte write-back of the attribute byte with that flag set. It waits for the acknowledge before it answers. A failed load returns a fault code and an exception vector and leaves the cached record as it was. One request is in flight at a time: a valid/ready handshake accepts it, and a one-cycle response pulse finishes it.

Top module: `seg_desc_loader`

## Requirements
- R1: `req_ready` is high only while the unit is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that point until the cycle after the response pulse.
- R2: On success the record gives the base as {desc[63:56], desc[39:32], desc[31:16]} and the raw limit as {desc[51:48], desc[15:0]}. Granularity is desc[55], default size is desc[54], the user bit is desc[52], DPL is desc[46:45] and the type is desc[43:41].
- R3: The effective limit is {limit, 12'hFFF} when granularity is 1, and the zero-extended 20-bit limit when it is 0.
- R4: Targets are encoded as code=0, stack=1, data=2. A code target needs S (desc[44]) = 1 and E (desc[43]) = 1. Any other combination returns the general-protection fault: code 1, vector 13.
- R5: A stack target needs S=1, E=0 and writable (desc[41]) = 1. A read-only data descriptor or a code descriptor returns fault code 1.
- R6: A data target needs S=1 and either E=0 or readable (desc[41]) = 1. An execute-only code descriptor returns fault code 1. Target value 3 always returns fault code 1.
- R7: A descriptor that passes the type rules but has P (desc[47]) = 0 returns the not-present fault: code 2, vector 11.
- R8: When a descriptor fails the type rules and is also not present, the type fault (code 1) is reported.
- R9: A successful load whose accessed flag (desc[40]) is 0 raises `wb_valid` with `wb_byte` = desc[47:40] with bit 0 set. Both are held until `wb_ready` is sampled high. The response pulse comes in the cycle after that acknowledge edge.
- R10: A successful load with the accessed flag at 1, and every faulted load, issue no write-back. Their response pulse comes in the second cycle after acceptance.
- R11: A fault leaves every record output unchanged. A successful load reports `rec_accessed` = 1.
- R12: `rsp_valid` is high for exactly one cycle per accepted request. On success `rsp_fault` is 0 and `rsp_vector` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit can accept a request |
| req_target | input | 2 | Destination register: 0 code, 1 stack, 2 data |
| req_desc | input | 64 | Raw descriptor |
| wb_valid | output | 1 | Attribute byte write-back request |
| wb_ready | input | 1 | Write-back acknowledge |
| wb_byte | output | 8 | Updated attribute byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 2 | 0 none, 1 protection, 2 not present |
| rsp_vector | output | 8 | Exception vector for the fault, 0 on success |
| rec_target | output | 2 | Register the record was loaded for |
| rec_base | output | 32 | Assembled base address |
| rec_limit | output | 20 | Raw limit |
| rec_limit_eff | output | 32 | Byte-granular limit |
| rec_gran | output | 1 | Granularity flag |
| rec_dflt | output | 1 | Default operand/stack size flag |
| rec_avl | output | 1 | User-available bit |
| rec_dpl | output | 2 | Descriptor privilege level |
| rec_type | output | 3 | Type field {E, C/ED, R/W} |
| rec_accessed | output | 1 | Accessed flag after the load |

## Verification
The bench aims at the type rules where the targets differ. An execute-only code descriptor is accepted by no target as data. A read-only data descriptor is fine for data and wrong for the stack. A design that mixes up the meaning of bit 1 between code and data would load one of these and skip its fault.

It checks a descriptor that is both of the wrong class and not present. A design with the priorities reversed would return vector 11 instead of 13.

The write-back is acknowledged only after several wait cycles. An early response, or a byte that drifts while it waits, shows up as a mismatch. A not-present fault that follows a good load checks that a design which writes the record on every load gets caught. The limit is checked under both granularities with fragments that are all different.

// File: rtl/seg_desc_pkg.sv
package seg_desc_pkg;

    localparam int DESC_W     = 64;
    localparam int BASE_W     = 32;
    localparam int LIM_W      = 20;
    localparam int GRAN_SHIFT = 12;
    localparam int ATTR_W     = 8;

    typedef enum logic [1:0] {
        TGT_CODE  = 2'd0,
        TGT_STACK = 2'd1,
        TGT_DATA  = 2'd2,
        TGT_RSVD  = 2'd3
    } seg_tgt_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_NP   = 2'd2
    } seg_fault_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic [BASE_W-1:0] limit_eff;
        logic              gran;
        logic              dflt;
        logic              avl;
        logic              present;
        logic [1:0]        dpl;
        logic              s_flag;
        logic              exec;     // E
        logic              dir_conf; // C for code, ED for data
        logic              rw;       // R for code, W for data
        logic              accessed;
        logic [ATTR_W-1:0] attr;
    } seg_rec_t;

    function automatic logic [BASE_W-1:0] expand_limit(input logic [LIM_W-1:0] lim,
                                                       input logic g);
        logic [BASE_W-1:0] r;
        if (g)
            r = {lim, {GRAN_SHIFT{1'b1}}};
        else
            r = {{(BASE_W-LIM_W){1'b0}}, lim};
        return r;
    endfunction

endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_desc_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output seg_rec_t          rec
);
    logic [31:0] lo_w;
    logic [31:0] hi_w;
    logic [7:0]  attr;

    assign lo_w = desc[31:0];
    assign hi_w = desc[63:32];
    assign attr = hi_w[15:8];

    always_comb begin
        rec           = '0;
        rec.base      = {hi_w[31:24], hi_w[7:0], lo_w[31:16]};
        rec.limit     = {hi_w[19:16], lo_w[15:0]};
        rec.gran      = hi_w[23];
        rec.dflt      = hi_w[22];
        rec.avl       = hi_w[20];
        rec.limit_eff = expand_limit(rec.limit, rec.gran);
        rec.present   = attr[7];
        rec.dpl       = attr[6:5];
        rec.s_flag    = attr[4];
        rec.exec      = attr[3];
        rec.dir_conf  = attr[2];
        rec.rw        = attr[1];
        rec.accessed  = attr[0];
        rec.attr      = attr;
    end
endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
    import seg_desc_pkg::*;
(
    input  seg_tgt_e   tgt,
    input  seg_rec_t   rec,
    output seg_fault_e fault
);
    logic type_ok;

    always_comb begin
        unique case (tgt)
            TGT_CODE:  type_ok = rec.s_flag && rec.exec;
            TGT_STACK: type_ok = rec.s_flag && !rec.exec && rec.rw;
            TGT_DATA:  type_ok = rec.s_flag && (!rec.exec || rec.rw);
            default:   type_ok = 1'b0;
        endcase
        // class/type failure outranks absence
        if (!type_ok)
            fault = FLT_GP;
        else if (!rec.present)
            fault = FLT_NP;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
    import seg_desc_pkg::*;
#(
    parameter logic [7:0] NP_VECTOR = 8'd11,
    parameter logic [7:0] GP_VECTOR = 8'd13
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_target,
    input  logic [63:0] req_desc,
    output logic        wb_valid,
    input  logic        wb_ready,
    output logic [7:0]  wb_byte,
    output logic        rsp_valid,
    output logic [1:0]  rsp_fault,
    output logic [7:0]  rsp_vector,
    output logic [1:0]  rec_target,
    output logic [31:0] rec_base,
    output logic [19:0] rec_limit,
    output logic [31:0] rec_limit_eff,
    output logic        rec_gran,
    output logic        rec_dflt,
    output logic        rec_avl,
    output logic [1:0]  rec_dpl,
    output logic [2:0]  rec_type,
    output logic        rec_accessed
);
    typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WB, ST_RESP} st_e;

    st_e               state;
    logic [DESC_W-1:0] desc_q;
    seg_tgt_e          tgt_q;
    seg_fault_e        fault_q;
    seg_rec_t          rec_c;
    seg_rec_t          rec_q;
    seg_tgt_e          rec_tgt_q;
    seg_fault_e        fault_c;

    seg_desc_unpack u_unpack (
        .desc (desc_q),
        .rec  (rec_c)
    );

    seg_desc_check u_check (
        .tgt   (tgt_q),
        .rec   (rec_c),
        .fault (fault_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            desc_q    <= '0;
            tgt_q     <= TGT_CODE;
            fault_q   <= FLT_NONE;
            rec_q     <= '0;
            rec_tgt_q <= TGT_CODE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        desc_q <= req_desc;
                        tgt_q  <= seg_tgt_e'(req_target);
                        state  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    fault_q <= fault_c;
                    if (fault_c != FLT_NONE) begin
                        state <= ST_RESP;
                    end else begin
                        rec_q          <= rec_c;
                        rec_q.accessed <= 1'b1;
                        rec_tgt_q      <= tgt_q;
                        state          <= rec_c.accessed ? ST_RESP : ST_WB;
                    end
                end
                ST_WB: begin
                    if (wb_ready)
                        state <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (fault_q)
            FLT_GP:  rsp_vector = GP_VECTOR;
            FLT_NP:  rsp_vector = NP_VECTOR;
            default: rsp_vector = 8'd0;
        endcase
    end

    assign req_ready     = (state == ST_IDLE);
    assign wb_valid      = (state == ST_WB);
    assign wb_byte       = {rec_c.attr[7:1], 1'b1};
    assign rsp_valid     = (state == ST_RESP);
    assign rsp_fault     = fault_q;
    assign rec_target    = rec_tgt_q;
    assign rec_base      = rec_q.base;
    assign rec_limit     = rec_q.limit;
    assign rec_limit_eff = rec_q.limit_eff;
    assign rec_gran      = rec_q.gran;
    assign rec_dflt      = rec_q.dflt;
    assign rec_avl       = rec_q.avl;
    assign rec_dpl       = rec_q.dpl;
    assign rec_type      = {rec_q.exec, rec_q.dir_conf, rec_q.rw};
    assign rec_accessed  = rec_q.accessed;
endmodule

// File: rtl/seg_desc_loader_chk.sv
module seg_desc_loader_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        wb_valid,
    input logic        wb_ready,
    input logic [7:0]  wb_byte,
    input logic        rsp_valid,
    input logic [1:0]  rsp_fault,
    input logic [7:0]  rsp_vector,
    input logic [31:0] rec_base,
    input logic [19:0] rec_limit
);
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r1_no_ready_in_resp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    a_r9_wb_hold: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_byte)));

    a_r9_wb_sets_flag: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_byte[0] && wb_byte[7] && wb_byte[4]));

    a_r9_resp_after_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(wb_valid) |-> rsp_valid);

    a_r10_no_wb_in_check: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !wb_valid);

    a_r11_fault_keeps_record: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> ($stable(rec_base) && $stable(rec_limit)));

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r7_np_vector: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == 2'd2) |-> (rsp_vector == 8'd11));
endmodule

bind seg_desc_loader seg_desc_loader_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .wb_valid   (wb_valid),
    .wb_ready   (wb_ready),
    .wb_byte    (wb_byte),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_vector (rsp_vector),
    .rec_base   (rec_base),
    .rec_limit  (rec_limit)
);

// File: tb/seg_desc_loader_bench.sv
module seg_desc_loader_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [1:0]  req_target;
    logic [63:0] req_desc;
    logic        wb_valid, wb_ready;
    logic [7:0]  wb_byte;
    logic        rsp_valid;
    logic [1:0]  rsp_fault;
    logic [7:0]  rsp_vector;
    logic [1:0]  rec_target;
    logic [31:0] rec_base, rec_limit_eff;
    logic [19:0] rec_limit;
    logic        rec_gran, rec_dflt, rec_avl, rec_accessed;
    logic [1:0]  rec_dpl;
    logic [2:0]  rec_type;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    seg_desc_loader u_seg_desc_loader (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_target(req_target), .req_desc(req_desc),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_byte(wb_byte),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_vector(rsp_vector),
        .rec_target(rec_target), .rec_base(rec_base), .rec_limit(rec_limit),
        .rec_limit_eff(rec_limit_eff), .rec_gran(rec_gran), .rec_dflt(rec_dflt),
        .rec_avl(rec_avl), .rec_dpl(rec_dpl), .rec_type(rec_type),
        .rec_accessed(rec_accessed)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] attr(input bit p, input logic [1:0] dpl, input bit s,
                                        input logic [2:0] ty, input bit a);
        return {p, dpl, s, ty, a};
    endfunction

    function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                       input bit g, input bit d, input bit avl,
                                       input logic [7:0] at);
        return {base[31:24], g, d, 1'b0, avl, lim[19:16], at, base[23:16],
                base[15:0], lim[15:0]};
    endfunction

    // Issue one request and check handshake, write-back and response timing.
    task automatic run_load(input logic [63:0] d, input logic [1:0] t,
                            input logic [1:0] exp_f, input bit exp_wb,
                            input int ack_delay, input string tag);
        logic [7:0] exp_vec;
        exp_vec = (exp_f == 2'd1) ? 8'd13 : (exp_f == 2'd2) ? 8'd11 : 8'd0;
        @(negedge clk);
        req_valid = 1'b1; req_desc = d; req_target = t;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R1 busy"}, req_ready, 0);
        if (exp_wb) begin
            @(negedge clk);
            chk({tag, " R9 wb_valid"}, wb_valid, 1);
            chk({tag, " R9 wb_byte"}, wb_byte, d[47:40] | 8'h01);
            for (int i = 0; i < ack_delay; i++) begin
                @(negedge clk);
                chk({tag, " R9 waits for ack"}, rsp_valid, 0);
                chk({tag, " R9 wb held"}, {wb_valid, wb_byte}, {1'b1, d[47:40] | 8'h01});
            end
            wb_ready = 1'b1;
            @(negedge clk);
            wb_ready = 1'b0;
            chk({tag, " R9 resp after ack"}, {rsp_valid, wb_valid}, 2'b10);
        end else begin
            @(negedge clk);
            chk({tag, " R10 no wb, resp"}, {rsp_valid, wb_valid}, 2'b10);
        end
        chk({tag, " fault code"}, rsp_fault, exp_f);
        chk({tag, " vector"}, rsp_vector, exp_vec);
        @(negedge clk);
        chk({tag, " R12 pulse ends"}, rsp_valid, 0);
        chk({tag, " R1 ready again"}, req_ready, 1);
    endtask

    task automatic chk_rec(input logic [31:0] base, input logic [19:0] lim, input bit g,
                           input bit d, input bit avl, input logic [1:0] dpl,
                           input logic [2:0] ty, input logic [1:0] t, input string tag);
        logic [31:0] eff;
        eff = g ? {lim, 12'hFFF} : {12'h000, lim};
        chk({tag, " R2 base"}, rec_base, base);
        chk({tag, " R2 limit"}, rec_limit, lim);
        chk({tag, " R3 eff limit"}, rec_limit_eff, eff);
        chk({tag, " R2 flags"}, {rec_gran, rec_dflt, rec_avl, rec_dpl, rec_type},
            {g, d, avl, dpl, ty});
        chk({tag, " R2 target"}, rec_target, t);
        chk({tag, " R11 accessed"}, rec_accessed, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset ready", req_ready, 1);
        chk("R12 reset no rsp", rsp_valid, 0);
        chk("R9 reset no wb", wb_valid, 0);
    endtask

    task automatic t_code_ok();   // R4 R9 R3 page granular
        run_load(mk(32'h12345678, 20'hABCDE, 1, 1, 1, attr(1, 2'd3, 1, 3'b101, 0)),
                 2'd0, 2'd0, 1, 3, "code_ok");
        chk_rec(32'h12345678, 20'hABCDE, 1, 1, 1, 2'd3, 3'b101, 2'd0, "code_ok");
    endtask

    task automatic t_data_ok();   // R6 R10 R3 byte granular
        run_load(mk(32'h9A00BC11, 20'h3F00F, 0, 0, 0, attr(1, 2'd1, 1, 3'b000, 1)),
                 2'd2, 2'd0, 0, 0, "data_ro_ok");
        chk_rec(32'h9A00BC11, 20'h3F00F, 0, 0, 0, 2'd1, 3'b000, 2'd2, "data_ro_ok");
    endtask

    task automatic t_stack_ok();  // R5 expand-down writable, immediate ack
        run_load(mk(32'h00FF0010, 20'h00123, 0, 1, 0, attr(1, 2'd0, 1, 3'b011, 0)),
                 2'd1, 2'd0, 1, 0, "stack_ok");
        chk_rec(32'h00FF0010, 20'h00123, 0, 1, 0, 2'd0, 3'b011, 2'd1, "stack_ok");
    endtask

    task automatic t_faults();
        // R5 read-only data rejected for stack; record must stay at stack_ok
        run_load(mk(32'hDEAD0000, 20'h11111, 1, 0, 0, attr(1, 2'd0, 1, 3'b000, 0)),
                 2'd1, 2'd1, 0, 0, "R5 stack_ro");
        chk_rec(32'h00FF0010, 20'h00123, 0, 1, 0, 2'd0, 3'b011, 2'd1, "R11 after gp");
        // R5 code rejected for stack
        run_load(mk(32'h0, 20'h0, 0, 0, 0, attr(1, 2'd0, 1, 3'b101, 0)),
                 2'd1, 2'd1, 0, 0, "R5 stack_code");
        // R4 data rejected for code
        run_load(mk(32'h0, 20'h0, 0, 0, 0, attr(1, 2'd0, 1, 3'b001, 0)),
                 2'd0, 2'd1, 0, 0, "R4 code_data");
        // R4 system descriptor rejected for code
        run_load(mk(32'h0, 20'h0, 0, 0, 0, attr(1, 2'd0, 0, 3'b101, 0)),
                 2'd0, 2'd1, 0, 0, "R4 code_sys");
        // R6 execute-only code rejected for data
        run_load(mk(32'h0, 20'h0, 0, 0, 0, attr(1, 2'd0, 1, 3'b100, 0)),
                 2'd2, 2'd1, 0, 0, "R6 data_xonly");
        // R6 reserved target
        run_load(mk(32'h0, 20'h0, 0, 0, 0, attr(1, 2'd0, 1, 3'b001, 0)),
                 2'd3, 2'd1, 0, 0, "R6 rsvd_tgt");
        // R7 not present
        run_load(mk(32'h55550000, 20'h22222, 0, 0, 0, attr(0, 2'd0, 1, 3'b001, 0)),
                 2'd2, 2'd2, 0, 0, "R7 not_present");
        chk_rec(32'h00FF0010, 20'h00123, 0, 1, 0, 2'd0, 3'b011, 2'd1, "R11 after np");
        // R8 wrong class and not present -> protection fault
        run_load(mk(32'h0, 20'h0, 0, 0, 0, attr(0, 2'd0, 0, 3'b001, 0)),
                 2'd2, 2'd1, 0, 0, "R8 priority");
    endtask

    task automatic t_code_as_data(); // R6 readable code into data register
        run_load(mk(32'h80000000, 20'hFFFFF, 1, 1, 0, attr(1, 2'd2, 1, 3'b111, 1)),
                 2'd2, 2'd0, 0, 0, "R6 data_rcode");
        chk_rec(32'h80000000, 20'hFFFFF, 1, 1, 0, 2'd2, 3'b111, 2'd2, "R6 data_rcode");
    endtask

    initial begin
        fork
            begin
                rst = 1'b1; req_valid = 1'b0; req_target = 2'd0; req_desc = '0;
                wb_ready = 1'b0;
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_code_ok();
                t_data_ok();
                t_stack_ok();
                t_faults();
                t_code_as_data();
            end
            begin
                repeat (200000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule